// File: doc/BRIEF.md
# Receiver Error Logging and Sample Hold

This block sits behind a digital audio receiver front end. With every stereo sample the front end presents a set of error flags: loss of clock lock, the received validity bit, a weak eye-opening confidence indication, a bi-phase coding violation, a parity error, a Q-subcode CRC error and a channel-status CRC error. The block qualifies each flag with a per-bit enable mask. It records enabled errors in a sticky status register that a read clears. It drives an error pulse and a level interrupt request.

The same qualified errors guard the audio path. When a sample carries an enabled error that affects audio, the outgoing sample is replaced according to a hold-mode setting. It can repeat the last clean sample, output zero, or pass the sample unchanged. The two CRC classes concern side-channel data, so they never alter the audio, even when they are enabled. A small register port gives access to the status, mask and hold-mode settings.

Top module: `rx_error_hold`

## Requirements
- R1: The register map is as follows. Address 0 is the status register, and a read of it clears it. Address 1 is the mask register, read/write. Address 2 is the hold mode in bits 1:0, read/write. In the status and mask registers the bit positions are: 0 lock lost, 1 validity, 2 confidence, 3 bi-phase, 4 parity, 5 Q-subcode CRC, 6 channel-status CRC. Read data appears on `reg_rdata` one cycle after `reg_rd` and holds its value until the next read.
- R2: When a sample is presented with an enabled error flag, the matching status bit sets at that clock edge. The bit stays set until the status register is read.
- R3: A status read returns the value held before the read and clears the register. An enabled error presented in the same cycle as the read remains set after the clear.
- R4: A mask bit of 1 enables its error. A masked error is not logged, produces no pulse and no interrupt, and does not alter the sample.
- R5: `err_pulse` is high for exactly the one cycle in which `out_valid` presents a sample that had any enabled error, and is low otherwise.
- R6: `irq` is high exactly while any status bit is set, starting in the same cycle that the bit appears.
- R7: Hold mode 00 replaces a sample that has an enabled audio-affecting error with the last sample that had no such error. After reset that sample is zero.
- R8: Hold mode 01 replaces a sample that has an enabled audio-affecting error with zero on both channels.
- R9: Hold modes 10 and 11 pass every sample unchanged.
- R10: Q-subcode CRC and channel-status CRC errors never change the sample, and they do not stop it from becoming the held sample.
- R11: After reset the status register, the mask register, the hold mode, the interrupt, the outputs and the read data are all zero.
- R12: Each input sample appears on `out_left`/`out_right` with `out_valid` high one clock after `in_valid`. Between samples `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (2) | Register address |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Registered read data |
| in_valid | input | 1 | Sample and error flags valid |
| in_err | input | ERR_N (7) | Per-sample error flags, in the same bit order as the status register |
| in_left | input | SAMPLE_W (24) | Left input sample |
| in_right | input | SAMPLE_W (24) | Right input sample |
| out_valid | output | 1 | Output sample valid |
| out_left | output | SAMPLE_W (24) | Left output sample |
| out_right | output | SAMPLE_W (24) | Right output sample |
| err_pulse | output | 1 | One-cycle pulse for a sample with an enabled error |
| irq | output | 1 | Interrupt request, level high while status is non-zero |

## Verification
Two actions can meet in one cycle: a software read that clears the status register, and the logging of a new enabled error. The bench first leaves one bit sticky. It then presents a sample with a different error in the very cycle of the status read. The read must return only the older bit, and a second read must return the new bit, with `irq` high in between. A walked table of mask, mode and error combinations then checks the audio substitution, the pulse, and the rule that the held sample comes only from clean samples.

// File: rtl/rxeg_pkg.sv
package rxeg_pkg;

  localparam int ERR_N = 7;

  localparam int E_LOCK  = 0;
  localparam int E_VALID = 1;
  localparam int E_CONF  = 2;
  localparam int E_BIPH  = 3;
  localparam int E_PAR   = 4;
  localparam int E_QCRC  = 5;
  localparam int E_CSCRC = 6;

  // Errors that may alter the audio path; the two CRC classes are excluded.
  localparam logic [ERR_N-1:0] AUDIO_ERR_SET =
    (ERR_N'(1) << E_LOCK) | (ERR_N'(1) << E_VALID) | (ERR_N'(1) << E_CONF) |
    (ERR_N'(1) << E_BIPH) | (ERR_N'(1) << E_PAR);

  localparam int ADDR_STATUS = 0;
  localparam int ADDR_MASK   = 1;
  localparam int ADDR_MODE   = 2;

  typedef enum logic [1:0] {
    HM_REPEAT   = 2'b00,
    HM_MUTE     = 2'b01,
    HM_PASS     = 2'b10,
    HM_PASS_ALT = 2'b11
  } hold_mode_e;

endpackage

// File: rtl/rxeg_regs.sv
module rxeg_regs
  import rxeg_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              err_vld,
  input  logic [ERR_N-1:0]  err_in,
  output logic [ERR_N-1:0]  mask_o,
  output hold_mode_e        mode_o,
  output logic              irq_o
);

  logic [ERR_N-1:0]  status_q, mask_q, new_err, status_d;
  hold_mode_e        mode_q;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;
  logic              rd_status, wr_mask, wr_mode;

  assign rd_status = rd && (addr == ADDR_W'(ADDR_STATUS));
  assign wr_mask   = wr && (addr == ADDR_W'(ADDR_MASK));
  assign wr_mode   = wr && (addr == ADDR_W'(ADDR_MODE));

  // Only enabled errors reach the sticky register; a same-cycle event survives the clear.
  assign new_err  = err_vld ? (err_in & mask_q) : '0;
  assign status_d = (rd_status ? '0 : status_q) | new_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      mode_q   <= HM_REPEAT;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |status_d;
      if (wr_mask) mask_q <= wdata[ERR_N-1:0];
      if (wr_mode) mode_q <= hold_mode_e'(wdata[1:0]);
      if (rd) begin
        if (addr == ADDR_W'(ADDR_STATUS))    rdata_q <= DATA_W'(status_q);
        else if (addr == ADDR_W'(ADDR_MASK)) rdata_q <= DATA_W'(mask_q);
        else if (addr == ADDR_W'(ADDR_MODE)) rdata_q <= DATA_W'(mode_q);
        else                                 rdata_q <= '0;
      end
    end
  end

  assign rdata  = rdata_q;
  assign mask_o = mask_q;
  assign mode_o = mode_q;
  assign irq_o  = irq_q;

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
    !rd_status |=> ((status_q & $past(status_q)) == $past(status_q))); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !err_vld) |=> (status_q == '0)); // R3
  AST_RACE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (rd_status && err_vld) |=> (status_q == $past(err_in & mask_q))); // R3
  AST_MASKED_SKIP: assert property (@(posedge clk) disable iff (rst)
    !rd_status |=> ((status_q & ~$past(mask_q) & ~$past(status_q)) == '0)); // R4

endmodule

// File: rtl/rxeg_hold.sv
module rxeg_hold
  import rxeg_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CH_N     = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_vld,
  input  logic [CH_N-1:0][SAMPLE_W-1:0] in_smp,
  input  logic [ERR_N-1:0]              err_in,
  input  logic [ERR_N-1:0]              mask,
  input  hold_mode_e                    mode,
  output logic                          out_vld,
  output logic [CH_N-1:0][SAMPLE_W-1:0] out_smp,
  output logic                          err_pulse
);

  logic [ERR_N-1:0] enabled;
  logic             any_err, audio_hit;
  logic             out_vld_q, pulse_q;

  assign enabled   = err_in & mask;
  assign any_err   = |enabled;
  assign audio_hit = |(enabled & AUDIO_ERR_SET);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      out_vld_q <= in_vld;
      pulse_q   <= in_vld && any_err;
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic [SAMPLE_W-1:0] prev_q, out_q, pick;

    always_comb begin
      pick = in_smp[c];
      if (audio_hit) begin
        case (mode)
          HM_REPEAT: pick = prev_q;
          HM_MUTE:   pick = '0;
          default:   pick = in_smp[c];
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= '0;
        out_q  <= '0;
      end else if (in_vld) begin
        out_q <= pick;
        if (!audio_hit) prev_q <= in_smp[c];
      end
    end

    assign out_smp[c] = out_q;
  end

  assign out_vld   = out_vld_q;
  assign err_pulse = pulse_q;

  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_vld && audio_hit && mode == HM_MUTE) |=> (out_smp == '0)); // R8
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (!audio_hit || mode == HM_PASS || mode == HM_PASS_ALT))
      |=> (out_smp == $past(in_smp))); // R9
  AST_NO_IDLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!err_pulse && !out_vld)); // R5
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_smp)); // R12

endmodule

// File: rtl/rx_error_hold.sv
module rx_error_hold
  import rxeg_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                in_valid,
  input  logic [ERR_N-1:0]    in_err,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                err_pulse,
  output logic                irq
);

  localparam int CH_N = 2;

  logic [ERR_N-1:0]              mask;
  hold_mode_e                    mode;
  logic [CH_N-1:0][SAMPLE_W-1:0] in_smp, out_smp;

  assign in_smp = {in_right, in_left};

  rxeg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .err_vld (in_valid),
    .err_in  (in_err),
    .mask_o  (mask),
    .mode_o  (mode),
    .irq_o   (irq)
  );

  rxeg_hold #(.SAMPLE_W(SAMPLE_W), .CH_N(CH_N)) hold_i (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_valid),
    .in_smp    (in_smp),
    .err_in    (in_err),
    .mask      (mask),
    .mode      (mode),
    .out_vld   (out_valid),
    .out_smp   (out_smp),
    .err_pulse (err_pulse)
  );

  assign out_left  = out_smp[0];
  assign out_right = out_smp[1];

  AST_PULSE_HAS_IRQ: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> irq); // R6

endmodule

// File: tb/rx_error_hold_tb.sv
module rx_error_hold_tb_top;

  localparam int SW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          in_valid = 1'b0;
  logic [6:0]    in_err = '0;
  logic [SW-1:0] in_left = '0, in_right = '0;
  logic          out_valid, err_pulse, irq;
  logic [SW-1:0] out_left, out_right;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  rx_error_hold dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_err(in_err), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .err_pulse(err_pulse), .irq(irq)
  );

  typedef struct packed {
    logic [7:0]    mask;
    logic [1:0]    mode;
    logic [6:0]    err;
    logic [SW-1:0] l, r, el, er;
    logic          ep;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h7F, 2'd2, 7'h00, 24'h000111, 24'h000222, 24'h000111, 24'h000222, 1'b0},
    '{8'h7F, 2'd0, 7'h08, 24'h000333, 24'h000444, 24'h000111, 24'h000222, 1'b1},
    '{8'h7F, 2'd0, 7'h10, 24'h000555, 24'h000666, 24'h000111, 24'h000222, 1'b1},
    '{8'h7F, 2'd1, 7'h01, 24'h000777, 24'h000888, 24'h000000, 24'h000000, 1'b1},
    '{8'h7F, 2'd2, 7'h02, 24'h000999, 24'h000AAA, 24'h000999, 24'h000AAA, 1'b1},
    '{8'h7F, 2'd0, 7'h20, 24'h000BBB, 24'h000CCC, 24'h000BBB, 24'h000CCC, 1'b1},
    '{8'h7F, 2'd1, 7'h40, 24'h000DDD, 24'h000EEE, 24'h000DDD, 24'h000EEE, 1'b1},
    '{8'h00, 2'd1, 7'h1F, 24'h000123, 24'h000456, 24'h000123, 24'h000456, 1'b0},
    '{8'h7F, 2'd3, 7'h04, 24'h000321, 24'h000654, 24'h000321, 24'h000654, 1'b1},
    '{8'h7E, 2'd0, 7'h01, 24'h0000A1, 24'h0000B2, 24'h0000A1, 24'h0000B2, 1'b0},
    '{8'h7E, 2'd0, 7'h02, 24'h0000C3, 24'h0000D4, 24'h0000A1, 24'h0000B2, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // Presents one sample; optionally reads status in the same cycle.
  task automatic send(input logic [6:0] e, input logic [SW-1:0] l, input logic [SW-1:0] r,
                      input logic rd_same);
    @(negedge clk);
    in_valid = 1'b1; in_err = e; in_left = l; in_right = r;
    if (rd_same) begin reg_rd = 1'b1; reg_addr = 2'd0; end
    @(negedge clk);
    in_valid = 1'b0; in_err = '0; reg_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk("R11 out_valid", 32'(out_valid), 0);
    chk("R11 out_left", 32'(out_left), 0);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 rdata", 32'(reg_rdata), 0);
    reg_read(2'd0, rv); chk("R11 status", 32'(rv), 0);
    reg_read(2'd1, rv); chk("R11 mask", 32'(rv), 0);
    reg_read(2'd2, rv); chk("R11 mode", 32'(rv), 0);

    // R4 all masked after reset: nothing logged, no pulse, mode 00 does not act
    send(7'h7F, 24'h00ABCD, 24'h00DCBA, 1'b0);
    chk("R4 masked pulse", 32'(err_pulse), 0);
    chk("R4 masked irq", 32'(irq), 0);
    chk("R4 masked sample", 32'(out_left), 32'h00ABCD);
    reg_read(2'd0, rv); chk("R4 masked status", 32'(rv), 0);

    // R1 mask and mode read back
    reg_write(2'd1, 8'h5A); reg_read(2'd1, rv); chk("R1 mask rw", 32'(rv), 32'h5A);
    reg_write(2'd2, 8'h02); reg_read(2'd2, rv); chk("R1 mode rw", 32'(rv), 32'h02);

    // Table walk: R7 R8 R9 R10 R5 R12
    for (int i = 0; i < NV; i++) begin
      reg_write(2'd1, VECS[i].mask);
      reg_write(2'd2, {6'd0, VECS[i].mode});
      send(VECS[i].err, VECS[i].l, VECS[i].r, 1'b0);
      chk($sformatf("R12 vec%0d out_valid", i), 32'(out_valid), 1);
      chk($sformatf("R7/R8/R9/R10 vec%0d left", i), 32'(out_left), 32'(VECS[i].el));
      chk($sformatf("R7/R8/R9/R10 vec%0d right", i), 32'(out_right), 32'(VECS[i].er));
      chk($sformatf("R5 vec%0d pulse", i), 32'(err_pulse), 32'(VECS[i].ep));
      @(negedge clk);
      chk($sformatf("R5 vec%0d pulse width", i), 32'(err_pulse), 0);
      chk($sformatf("R12 vec%0d idle", i), 32'(out_valid), 0);
    end

    // R3 clear leftover status
    reg_read(2'd0, rv);
    reg_read(2'd0, rv); chk("R3 cleared", 32'(rv), 0);
    chk("R6 irq low when clear", 32'(irq), 0);

    // R2 sticky, R6 irq level
    reg_write(2'd1, 8'h7F);
    send(7'h04, 24'h1, 24'h2, 1'b0);
    chk("R6 irq with bit", 32'(irq), 1);
    send(7'h00, 24'h3, 24'h4, 1'b0);
    chk("R2 sticky irq", 32'(irq), 1);
    reg_read(2'd0, rv); chk("R2 status confidence bit2", 32'(rv), 32'h04);
    chk("R6 irq after read", 32'(irq), 0);

    // R3 error in the same cycle as the clearing read
    send(7'h08, 24'h5, 24'h6, 1'b0);
    send(7'h10, 24'h7, 24'h8, 1'b1);
    chk("R3 race read old", 32'(reg_rdata), 32'h08);
    chk("R3 race irq", 32'(irq), 1);
    reg_read(2'd0, rv); chk("R3 race new kept", 32'(rv), 32'h10);
    chk("R6 irq cleared", 32'(irq), 0);

    // R10 CRC errors logged but sample untouched in mute mode
    reg_write(2'd2, 8'h01);
    send(7'h60, 24'h00F00D, 24'h00BEEF, 1'b0);
    chk("R10 crc left", 32'(out_left), 32'h00F00D);
    reg_read(2'd0, rv); chk("R1 crc bits 5,6", 32'(rv), 32'h60);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule